// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits on the write side of a 16-bit word-wide non-volatile memory and turns write bus cycles into operating modes and operation requests. Every command is guarded by two fixed unlock writes (data AA to address 555, then data 55 to address 2AA) followed by a command byte at address 555. From that stream it selects array read, identification read or the secure-region mapping. It issues a one-cycle program request carrying the captured address and data, or a one-cycle chip-erase request, to a separate program/erase engine.

While identification mode is active the block supplies the identification word for the current read offset. While the secure mapping is on, it flags reads that fall in the low 512 words so that they can be steered to the separate secure region. Any write that does not fit the expected sequence silently discards the sequence. A single F0 write cancels everything except the secure mapping. An acceleration input lets a program command be accepted without the unlock writes. The engine's busy flag blocks all writes while an operation runs.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, and after any later hardware reset, the block is in array read (`mode_array`=1, `mode_id`=0, `mode_sec`=0) with no request pulse.
- R2: A write counts only when `bus_ce`=1, `bus_we`=1 and `bus_oe`=0 in the same cycle. Any other combination changes neither the modes nor the sequence progress.
- R3: AA@555, 55@2AA, 90@555 sets `mode_id` in the cycle after the third write. While `mode_id`=1, `id_word` is taken from address bits [7:0]: 00 gives 00C2, 01 gives 22FE, 03 gives 0088 (factory-locked build, the default) or 0008, and any other offset gives 0000. `id_word` is 0000 whenever `mode_id`=0.
- R4: AA@555, 55@2AA, A0@555 followed by one write at any address raises `prog_start` for exactly the cycle after that write, with `prog_addr`/`prog_data` equal to its address and data. That fourth write is always taken as program data, even when its data is F0.
- R5: The six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 raise `erase_start` for exactly the cycle after the sixth. `prog_start` and `erase_start` are never high together.
- R6: A write with the wrong address (low 11 bits) or the wrong data (low byte) for the current step discards the sequence and clears `mode_id`. The secure mapping is kept.
- R7: A write of data F0 at any address, in any step except the program-data step, discards the sequence and clears `mode_id`.
- R8: AA@555, 55@2AA, 88@555 sets `mode_sec` and clears `mode_id`. While `mode_sec`=1, `sec_sel` is 1 exactly when address bits [19:9] are zero, and `sec_offs` is address bits [8:0].
- R9: While `mode_sec`=1, AA@555, 55@2AA, 90@555 followed by data 00 at any address clears `mode_sec`, and identification mode is not entered.
- R10: While `accel_en`=1, a single A0@555 write from the idle step opens the program-data step directly. With `accel_en`=0 the same write is a bad cycle.
- R11: While `eng_busy`=1 every write is dropped: no request, no mode or sequence change.
- R12: Address bits above bit 10 are ignored when matching the unlock and command addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_ce | input | 1 | Chip enable, active high |
| bus_we | input | 1 | Write strobe, one-cycle pulse, active high |
| bus_oe | input | 1 | Output enable, active high |
| bus_addr | input | ADDR_W (20) | Bus word address |
| bus_wdata | input | DATA_W (16) | Bus write data |
| accel_en | input | 1 | Acceleration: skip the unlock writes for programming |
| eng_busy | input | 1 | Program/erase engine running |
| mode_array | output | 1 | Array read mode |
| mode_id | output | 1 | Identification mode |
| mode_sec | output | 1 | Secure-region mapping on |
| sec_sel | output | 1 | Current address maps into the secure region |
| sec_offs | output | 9 | Word offset inside the secure region |
| id_word | output | DATA_W (16) | Identification word for the current offset |
| prog_start | output | 1 | Program request pulse |
| prog_addr | output | ADDR_W (20) | Address to program |
| prog_data | output | DATA_W (16) | Data to program |
| erase_start | output | 1 | Chip-erase request pulse |

## Verification
Mode flags and the two request pulses come from registers. They are due in the first cycle after the clock edge that samples the deciding write. `id_word`, `sec_sel` and `sec_offs` are combinational from the mode registers and the present address, so they are due in the same cycle as a read address. The driver tags every expected item with the cycle number one edge after the one it drives, and applies inputs on the falling edge. The monitor samples one nanosecond after each rising edge and compares only the items due in that cycle, so every check lands exactly where the result is due.

// File: rtl/cmdec_pkg.sv
package cmdec_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,   // waiting for first unlock write
      SQ_UNL1,   // first unlock seen
      SQ_UNL2,   // second unlock seen, command byte next
      SQ_PGM,    // next write is program address/data
      SQ_ER1,    // erase set-up seen, second unlock pair next
      SQ_ER2,
      SQ_ER3,    // chip erase confirm next
      SQ_EXIT    // secure exit, data 00 next
   } seq_t;

   localparam logic [7:0] CMD_UNL_A = 8'hAA;
   localparam logic [7:0] CMD_UNL_B = 8'h55;
   localparam logic [7:0] CMD_PGM   = 8'hA0;
   localparam logic [7:0] CMD_ERSU  = 8'h80;
   localparam logic [7:0] CMD_CHIP  = 8'h10;
   localparam logic [7:0] CMD_IDENT = 8'h90;
   localparam logic [7:0] CMD_SECEN = 8'h88;
   localparam logic [7:0] CMD_RESET = 8'hF0;
   localparam logic [7:0] CMD_SECX  = 8'h00;

   localparam logic [10:0] ADR_UNL_A = 11'h555;
   localparam logic [10:0] ADR_UNL_B = 11'h2AA;

   localparam logic [15:0] IDW_MAKER   = 16'h00C2;
   localparam logic [15:0] IDW_DEVICE  = 16'h22FE;
   localparam logic [15:0] IDW_LOCKED  = 16'h0088;
   localparam logic [15:0] IDW_OPEN    = 16'h0008;

endpackage

// File: rtl/cmdec_wrq.sv
module cmdec_wrq
   import cmdec_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int UNLOCK_AW = 11
)(
   input  logic              bus_ce,
   input  logic              bus_we,
   input  logic              bus_oe,
   input  logic              eng_busy,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_ok,
   output logic              hit_a,
   output logic              hit_b
);
   localparam logic [UNLOCK_AW-1:0] MATCH_A = UNLOCK_AW'(ADR_UNL_A);
   localparam logic [UNLOCK_AW-1:0] MATCH_B = UNLOCK_AW'(ADR_UNL_B);

   logic [UNLOCK_AW-1:0] low_addr;

   assign low_addr = bus_addr[UNLOCK_AW-1:0];
   assign wr_ok    = bus_ce & bus_we & ~bus_oe & ~eng_busy;
   assign hit_a    = (low_addr == MATCH_A);
   assign hit_b    = (low_addr == MATCH_B);
endmodule

// File: rtl/cmdec_seq.sv
module cmdec_seq
   import cmdec_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic              hit_a,
   input  logic              hit_b,
   input  logic              accel_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              mode_id,
   output logic              mode_sec,
   output logic              prog_start,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_start
);
   seq_t       seq_q, seq_d;
   logic       id_d, sec_d, ps_d, es_d, cap;
   logic [7:0] cb;

   assign cb = bus_wdata[7:0];

   always_comb begin
      seq_d = seq_q;
      id_d  = mode_id;
      sec_d = mode_sec;
      ps_d  = 1'b0;
      es_d  = 1'b0;
      cap   = 1'b0;
      if (wr_ok) begin
         if (seq_q == SQ_PGM) begin
            ps_d  = 1'b1;
            cap   = 1'b1;
            seq_d = SQ_IDLE;
            id_d  = 1'b0;
         end else if (cb == CMD_RESET) begin
            seq_d = SQ_IDLE;
            id_d  = 1'b0;
         end else begin
            // default outcome of every step is the abort
            seq_d = SQ_IDLE;
            id_d  = 1'b0;
            unique case (seq_q)
               SQ_IDLE: begin
                  if (accel_en && hit_a && cb == CMD_PGM) begin
                     seq_d = SQ_PGM;
                     id_d  = mode_id;
                  end else if (hit_a && cb == CMD_UNL_A) begin
                     seq_d = SQ_UNL1;
                     id_d  = mode_id;
                  end
               end
               SQ_UNL1: begin
                  if (hit_b && cb == CMD_UNL_B) begin
                     seq_d = SQ_UNL2;
                     id_d  = mode_id;
                  end
               end
               SQ_UNL2: begin
                  if (hit_a) begin
                     unique case (cb)
                        CMD_PGM:   begin seq_d = SQ_PGM; id_d = mode_id; end
                        CMD_ERSU:  begin seq_d = SQ_ER1; id_d = mode_id; end
                        CMD_IDENT: begin
                           if (mode_sec) begin
                              seq_d = SQ_EXIT;
                              id_d  = mode_id;
                           end else begin
                              id_d  = 1'b1;
                           end
                        end
                        CMD_SECEN: sec_d = 1'b1;
                        default:   ;
                     endcase
                  end
               end
               SQ_ER1: begin
                  if (hit_a && cb == CMD_UNL_A) begin
                     seq_d = SQ_ER2;
                     id_d  = mode_id;
                  end
               end
               SQ_ER2: begin
                  if (hit_b && cb == CMD_UNL_B) begin
                     seq_d = SQ_ER3;
                     id_d  = mode_id;
                  end
               end
               SQ_ER3: begin
                  if (hit_a && cb == CMD_CHIP) es_d = 1'b1;
               end
               SQ_EXIT: begin
                  if (cb == CMD_SECX) sec_d = 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q       <= SQ_IDLE;
         mode_id     <= 1'b0;
         mode_sec    <= 1'b0;
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         prog_addr   <= '0;
         prog_data   <= '0;
      end else begin
         seq_q       <= seq_d;
         mode_id     <= id_d;
         mode_sec    <= sec_d;
         prog_start  <= ps_d;
         erase_start <= es_d;
         if (cap) begin
            prog_addr <= bus_addr;
            prog_data <= bus_wdata;
         end
      end
   end
endmodule

// File: rtl/cmdec_idrom.sv
module cmdec_idrom
   import cmdec_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int IDOFF_W        = 8,
   parameter bit FACTORY_LOCKED = 1'b1
)(
   input  logic               mode_id,
   input  logic [IDOFF_W-1:0] offs,
   output logic [DATA_W-1:0]  id_word
);
   logic [15:0] lock_word;

   generate
      if (FACTORY_LOCKED) begin : g_locked
         assign lock_word = IDW_LOCKED;
      end else begin : g_open
         assign lock_word = IDW_OPEN;
      end
   endgenerate

   always_comb begin
      id_word = '0;
      if (mode_id) begin
         unique case (offs)
            IDOFF_W'(0): id_word = DATA_W'(IDW_MAKER);
            IDOFF_W'(1): id_word = DATA_W'(IDW_DEVICE);
            IDOFF_W'(3): id_word = DATA_W'(lock_word);
            default:     id_word = '0;
         endcase
      end
   end
endmodule

// File: rtl/cmdec_secmap.sv
module cmdec_secmap #(
   parameter int ADDR_W    = 20,
   parameter int SEC_WORDS = 512,
   localparam int SEC_AW   = $clog2(SEC_WORDS)
)(
   input  logic              mode_sec,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              sec_sel,
   output logic [SEC_AW-1:0] sec_offs
);
   generate
      if (SEC_AW < ADDR_W) begin : g_part
         assign sec_sel = mode_sec && (bus_addr[ADDR_W-1:SEC_AW] == '0);
      end else begin : g_full
         assign sec_sel = mode_sec;
      end
   endgenerate
   assign sec_offs = bus_addr[SEC_AW-1:0];
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
   import cmdec_pkg::*;
#(
   parameter int ADDR_W         = 20,
   parameter int DATA_W         = 16,
   parameter int UNLOCK_AW      = 11,
   parameter int IDOFF_W        = 8,
   parameter int SEC_WORDS      = 512,
   parameter bit FACTORY_LOCKED = 1'b1,
   localparam int SEC_AW        = $clog2(SEC_WORDS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce,
   input  logic              bus_we,
   input  logic              bus_oe,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              accel_en,
   input  logic              eng_busy,
   output logic              mode_array,
   output logic              mode_id,
   output logic              mode_sec,
   output logic              sec_sel,
   output logic [SEC_AW-1:0] sec_offs,
   output logic [DATA_W-1:0] id_word,
   output logic              prog_start,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              erase_start
);
   if (DATA_W < 16) begin : g_chk_dw
      $error("DATA_W must be at least 16");
   end
   if (UNLOCK_AW < 10 || UNLOCK_AW > ADDR_W) begin : g_chk_uaw
      $error("UNLOCK_AW must lie between 10 and ADDR_W");
   end
   if (IDOFF_W < 2 || IDOFF_W > ADDR_W) begin : g_chk_ido
      $error("IDOFF_W must lie between 2 and ADDR_W");
   end
   if (SEC_WORDS < 2 || (1 << SEC_AW) != SEC_WORDS || SEC_AW > ADDR_W) begin : g_chk_sec
      $error("SEC_WORDS must be a power of two that fits the address");
   end

   logic wr_ok, hit_a, hit_b;

   cmdec_wrq #(.ADDR_W(ADDR_W), .UNLOCK_AW(UNLOCK_AW)) wrq_i (
      .bus_ce(bus_ce), .bus_we(bus_we), .bus_oe(bus_oe), .eng_busy(eng_busy),
      .bus_addr(bus_addr), .wr_ok(wr_ok), .hit_a(hit_a), .hit_b(hit_b)
   );

   cmdec_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .hit_a(hit_a), .hit_b(hit_b),
      .accel_en(accel_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .mode_id(mode_id), .mode_sec(mode_sec), .prog_start(prog_start),
      .prog_addr(prog_addr), .prog_data(prog_data), .erase_start(erase_start)
   );

   cmdec_idrom #(.DATA_W(DATA_W), .IDOFF_W(IDOFF_W), .FACTORY_LOCKED(FACTORY_LOCKED)) idrom_i (
      .mode_id(mode_id), .offs(bus_addr[IDOFF_W-1:0]), .id_word(id_word)
   );

   cmdec_secmap #(.ADDR_W(ADDR_W), .SEC_WORDS(SEC_WORDS)) secmap_i (
      .mode_sec(mode_sec), .bus_addr(bus_addr), .sec_sel(sec_sel), .sec_offs(sec_offs)
   );

   assign mode_array = ~mode_id & ~mode_sec;
endmodule

// File: rtl/cmd_seq_decoder_chk.sv
module cmd_seq_decoder_chk #(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int SEC_WORDS = 512,
   localparam int SEC_AW   = $clog2(SEC_WORDS)
)(
   input logic              clk,
   input logic              rst_n,
   input logic              bus_ce,
   input logic              bus_we,
   input logic              bus_oe,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              eng_busy,
   input logic              mode_array,
   input logic              mode_id,
   input logic              mode_sec,
   input logic              sec_sel,
   input logic [DATA_W-1:0] id_word,
   input logic              prog_start,
   input logic              erase_start
);
   assert_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ce && bus_we && !bus_oe) |=> (!prog_start && !erase_start &&
                                          $stable(mode_id) && $stable(mode_sec)));

   assert_idword_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_id |-> (id_word == '0));

   assert_prog_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);

   assert_erase_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !erase_start);

   assert_starts_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_start && erase_start));

   assert_modes_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({mode_array, mode_id, mode_sec}) == 1);

   assert_secsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_sel |-> (mode_sec && bus_addr[ADDR_W-1:SEC_AW] == '0));

   assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> (!prog_start && !erase_start && $stable(mode_id) && $stable(mode_sec)));
endmodule

bind cmd_seq_decoder cmd_seq_decoder_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_WORDS(SEC_WORDS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_we(bus_we), .bus_oe(bus_oe),
   .bus_addr(bus_addr), .eng_busy(eng_busy), .mode_array(mode_array),
   .mode_id(mode_id), .mode_sec(mode_sec), .sec_sel(sec_sel), .id_word(id_word),
   .prog_start(prog_start), .erase_start(erase_start)
);

// File: tb/cmd_seq_decoder_tb_top.sv
module cmd_seq_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_ce = 1'b0, bus_we = 1'b0, bus_oe = 1'b0;
   logic [19:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        accel_en = 1'b0, eng_busy = 1'b0;
   logic        mode_array, mode_id, mode_sec, sec_sel, prog_start, erase_start;
   logic [8:0]  sec_offs;
   logic [15:0] id_word, prog_data;
   logic [19:0] prog_addr;

   always #2 clk = ~clk;   // 250 MHz

   cmd_seq_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_we(bus_we), .bus_oe(bus_oe),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .accel_en(accel_en), .eng_busy(eng_busy),
      .mode_array(mode_array), .mode_id(mode_id), .mode_sec(mode_sec), .sec_sel(sec_sel),
      .sec_offs(sec_offs), .id_word(id_word), .prog_start(prog_start),
      .prog_addr(prog_addr), .prog_data(prog_data), .erase_start(erase_start)
   );

   typedef struct {
      int          due;
      logic        eid, esec, eps, ees, essel;
      logic [15:0] eidw;
      logic [19:0] ea;
      logic [15:0] ed;
      string       req;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_vec = 0;
   int    n_bad = 0;

   function automatic logic [15:0] exp_idw(input logic eid, input logic [19:0] a);
      if (!eid) return 16'h0000;
      case (a[7:0])
         8'h00:   return 16'h00C2;
         8'h01:   return 16'h22FE;
         8'h03:   return 16'h0088;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic drive(input logic ce, input logic we, input logic oe,
                        input logic [19:0] a, input logic [15:0] d,
                        input logic eid, input logic esec, input logic eps,
                        input logic ees, input string req);
      item_t it;
      @(negedge clk);
      bus_ce = ce; bus_we = we; bus_oe = oe; bus_addr = a; bus_wdata = d;
      it.due = cyc + 1; it.eid = eid; it.esec = esec; it.eps = eps; it.ees = ees;
      it.essel = esec && (a[19:9] == 11'd0);
      it.eidw = exp_idw(eid, a);
      it.ea = a; it.ed = d; it.req = req;
      q.push_back(it);
   endtask

   task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic eid,
                     input logic esec, input logic eps, input logic ees, input string req);
      drive(1'b1, 1'b1, 1'b0, a, d, eid, esec, eps, ees, req);
   endtask

   task automatic rd(input logic [19:0] a, input logic eid, input logic esec, input string req);
      drive(1'b1, 1'b0, 1'b1, a, 16'h0, eid, esec, 1'b0, 1'b0, req);
   endtask

   // monitor: pops items due in this cycle and compares
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            logic  bad;
            it = q.pop_front();
            n_vec++;
            bad = (mode_id !== it.eid) || (mode_sec !== it.esec) ||
                  (mode_array !== (!it.eid && !it.esec)) ||
                  (prog_start !== it.eps) || (erase_start !== it.ees) ||
                  (sec_sel !== it.essel) || (id_word !== it.eidw) ||
                  (it.esec && sec_offs !== it.ea[8:0]) ||
                  (it.eps && (prog_addr !== it.ea || prog_data !== it.ed));
            if (bad) begin
               n_bad++;
               $display("FAIL %s cyc %0d: act id=%b sec=%b arr=%b ps=%b es=%b ssel=%b idw=%h pa=%h pd=%h | exp id=%b sec=%b ps=%b es=%b ssel=%b idw=%h pa=%h pd=%h",
                        it.req, cyc, mode_id, mode_sec, mode_array, prog_start, erase_start,
                        sec_sel, id_word, prog_addr, prog_data, it.eid, it.esec, it.eps,
                        it.ees, it.essel, it.eidw, it.ea, it.ed);
            end
         end
      end
   end

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rd(20'h00000, 0, 0, "R1 reset state");
      rst_n = 1'b1;
      rd(20'h00000, 0, 0, "R1 after release");

      // R2: inhibited write in the middle does not break the sequence
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R2 unlock A");
      drive(1'b0, 1'b1, 1'b0, 20'h002AA, 16'h0033, 0, 0, 0, 0, "R2 ce low ignored");
      drive(1'b1, 1'b1, 1'b1, 20'h00123, 16'h0077, 0, 0, 0, 0, "R2 oe high ignored");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R2 unlock B");
      wr(20'h00555, 16'h0090, 1, 0, 0, 0, "R3 enter id");

      // R3: identification words
      rd(20'h00000, 1, 0, "R3 maker word");
      rd(20'h00001, 1, 0, "R3 device word");
      rd(20'h00003, 1, 0, "R3 lock word");
      rd(20'h00002, 1, 0, "R3 unused offset");
      rd(20'h12301, 1, 0, "R3 upper bits ignored");
      wr(20'h00007, 16'h00F0, 0, 0, 0, 0, "R7 F0 leaves id");
      rd(20'h00000, 0, 0, "R3 zero outside id");

      // R4: program
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R4 unlock A");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R4 unlock B");
      wr(20'h00555, 16'h00A0, 0, 0, 0, 0, "R4 program cmd");
      wr(20'h3ABCD, 16'h1234, 0, 0, 1, 0, "R4 program request");
      rd(20'h00000, 0, 0, "R4 pulse ends");
      // R4: F0 as program data
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R4 unlock A");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R4 unlock B");
      wr(20'h00555, 16'h00A0, 0, 0, 0, 0, "R4 program cmd");
      wr(20'h00040, 16'h00F0, 0, 0, 1, 0, "R4 F0 taken as data");

      // R11: busy drops writes
      @(negedge clk); eng_busy = 1'b1;
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R11 dropped");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R11 dropped");
      wr(20'h00555, 16'h00A0, 0, 0, 0, 0, "R11 dropped");
      wr(20'h00100, 16'hBEEF, 0, 0, 0, 0, "R11 no program");
      @(negedge clk); eng_busy = 1'b0;
      wr(20'h00100, 16'hBEEF, 0, 0, 0, 0, "R11 sequence did not advance");

      // R5: chip erase
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R5 w1");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R5 w2");
      wr(20'h00555, 16'h0080, 0, 0, 0, 0, "R5 w3");
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R5 w4");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R5 w5");
      wr(20'h00555, 16'h0010, 0, 0, 0, 1, "R5 erase request");
      rd(20'h00000, 0, 0, "R5 pulse ends");

      // R6: wrong address aborts
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R6 unlock A");
      wr(20'h002AB, 16'h0055, 0, 0, 0, 0, "R6 wrong address");
      wr(20'h00555, 16'h0090, 0, 0, 0, 0, "R6 no id entry");
      // R6: wrong data clears id mode
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R6 unlock A");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R6 unlock B");
      wr(20'h00555, 16'h0090, 1, 0, 0, 0, "R6 enter id");
      wr(20'h00555, 16'h0012, 0, 0, 0, 0, "R6 bad write leaves id");

      // R7: F0 mid sequence
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R7 unlock A");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R7 unlock B");
      wr(20'h0F0F0, 16'h00F0, 0, 0, 0, 0, "R7 reset cmd");
      wr(20'h00555, 16'h00A0, 0, 0, 0, 0, "R7 A0 alone");
      wr(20'h00200, 16'h5555, 0, 0, 0, 0, "R7 no program");

      // R8: secure mapping
      wr(20'h00555, 16'h00AA, 0, 0, 0, 0, "R8 unlock A");
      wr(20'h002AA, 16'h0055, 0, 0, 0, 0, "R8 unlock B");
      wr(20'h00555, 16'h0088, 0, 1, 0, 0, "R8 enter secure");
      rd(20'h001FF, 0, 1, "R8 top of region");
      rd(20'h00200, 0, 1, "R8 just outside");
      rd(20'h80000, 0, 1, "R8 high address");
      wr(20'h00555, 16'h0033, 0, 1, 0, 0, "R6 bad write keeps secure");
      wr(20'h00000, 16'h00F0, 0, 1, 0, 0, "R7 F0 keeps secure");

      // R9: secure exit
      wr(20'h00555, 16'h00AA, 0, 1, 0, 0, "R9 unlock A");
      wr(20'h002AA, 16'h0055, 0, 1, 0, 0, "R9 unlock B");
      wr(20'h00555, 16'h0090, 0, 1, 0, 0, "R9 exit cmd no id");
      wr(20'h04444, 16'h0000, 0, 0, 0, 0, "R9 secure off");
      rd(20'h00005, 0, 0, "R9 no mapping");

      // R10: acceleration
      @(negedge clk); accel_en = 1'b1;
      wr(20'h00555, 16'h00A0, 0, 0, 0, 0, "R10 accel program cmd");
      wr(20'h0ACE1, 16'hCAFE, 0, 0, 1, 0, "R10 accel program request");
      @(negedge clk); accel_en = 1'b0;
      wr(20'h00555, 16'h00A0, 0, 0, 0, 0, "R10 no accel");
      wr(20'h0ACE1, 16'hCAFE, 0, 0, 0, 0, "R10 no program without accel");

      // R12: upper address bits ignored
      wr(20'hFF555, 16'h00AA, 0, 0, 0, 0, "R12 unlock A high");
      wr(20'h812AA, 16'h0055, 0, 0, 0, 0, "R12 unlock B high");
      wr(20'h7F555, 16'h0090, 1, 0, 0, 0, "R12 id entry");

      // R1: hardware reset from secure mode
      wr(20'h00555, 16'h00AA, 1, 0, 0, 0, "R1 unlock A");
      wr(20'h002AA, 16'h0055, 1, 0, 0, 0, "R1 unlock B");
      wr(20'h00555, 16'h0088, 0, 1, 0, 0, "R1 enter secure");
      @(negedge clk); rst_n = 1'b0;
      rd(20'h00010, 0, 0, "R1 hw reset");
      rst_n = 1'b1;
      rd(20'h00010, 0, 0, "R1 after hw reset");

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: act %0d items left exp 0", q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule